// File: doc/BRIEF.md
# Contactless ID frame serializer

This block produces the 64-bit identification frame of a passive read-only tag and presents it one bit at a time. A 40-bit identifier from registers is placed in a grid of ten rows by four columns. Each row gets an even parity bit, and each column gets a parity bit in a closing group. A run of nine ones leads the frame and a single zero ends it. Row parity makes a run of nine ones impossible anywhere after the leading run, so a reader can find frame boundaries.

The line encoder pulses `bit_adv_i` once per bit period. Each pulse moves the block to the next frame bit. After the last bit the frame restarts at once with no gap, and this goes on for as long as reset is released. There is no request and no handshake.

The identifier is sampled while the header is being sent. It is frozen from the first data bit to the end of the frame, so every frame on the wire is self-consistent.

Top module: `id_frame_serializer`

## Requirements
- R1: While `rst_ni` is low and directly after it is released, `bit_idx_o` is 0, `frame_start_o` is 1 and `bit_o` is 1.
- R2: `bit_idx_o` increases by exactly one on each clock edge at which `bit_adv_i` is high, and holds its value on every other edge.
- R3: When `bit_adv_i` is high at index 63, the next index is 0, with no idle bit in between.
- R4: Indices 0 to 8 (the header) carry 1.
- R5: For row r (0..9) and column c (0..3), index 9+5r+c carries `id_i[39-4r-c]`. The customer field is therefore `id_i[39:32]` (rows 0 and 1), and data bits are sent row by row, lowest column first.
- R6: Index 13+5r carries the XOR of the four data bits of row r, which gives even parity over the row.
- R7: Index 59+c carries the XOR of the ten data bits of column c.
- R8: Index 63 carries 0.
- R9: `frame_start_o` is high exactly while `bit_idx_o` is 0.
- R10: The identifier used by a frame is the value of `id_i` at the last clock edge at which the index was below 9. A change of `id_i` at index 9 or above does not affect the rest of that frame; it appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_i | input | 40 | Identifier; bit 39 is the first data bit sent |
| bit_adv_i | input | 1 | Advance to the next frame bit |
| bit_o | output | 1 | Current frame bit |
| frame_start_o | output | 1 | High while header bit 0 is presented |
| bit_idx_o | output | 6 | Index of the current frame bit |

## Verification
A wrong index counter shows at the ports straight away: `bit_idx_o` comes out of the counter register, so a skipped, repeated or late wrap is visible one clock after the strobe that caused it, and `frame_start_o` moves with it. A wrong frame bit or a wrong captured identifier shows only when its slot comes up. That can be as late as 54 strobes after the header for the closing column parity. For that reason every index of every frame is compared, including frames in which the identifier changes inside the header and inside the data part.

// File: rtl/idfs_pkg.sv
package idfs_pkg;
  localparam int unsigned DEF_ROWS = 10;
  localparam int unsigned DEF_COLS = 4;
  localparam int unsigned DEF_HDR  = 9;

  // total bits: header, rows of data plus parity, column parity group, stop bit
  function automatic int unsigned frame_len(int unsigned rows, int unsigned cols,
                                            int unsigned hdr);
    return hdr + rows * (cols + 1) + cols + 1;
  endfunction
endpackage

// File: rtl/idfs_bit_counter.sv
module idfs_bit_counter #(
  parameter int unsigned LEN   = 64,
  parameter int unsigned IDX_W = $clog2(LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  assert_idx_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
  assert_idx_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1);
  assert_idx_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q == LAST) |=> idx_q == '0);
endmodule

// File: rtl/idfs_id_capture.sv
module idfs_id_capture #(
  parameter int unsigned ID_W    = 40,
  parameter int unsigned HDR_LEN = 9,
  parameter int unsigned IDX_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ID_W-1:0]  id_i,
  output logic [ID_W-1:0]  id_o
);
  localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(HDR_LEN);

  logic [ID_W-1:0] snap_q;
  logic            open;

  // identifier is only sampled while header bits, which do not use it, are out
  assign open = idx_i < FIRST_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (open) snap_q <= id_i;
  end

  assign id_o = snap_q;

  assert_snap_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i >= FIRST_DATA) |=> $stable(snap_q));
endmodule

// File: rtl/idfs_frame_builder.sv
module idfs_frame_builder #(
  parameter int unsigned ROWS    = 10,
  parameter int unsigned COLS    = 4,
  parameter int unsigned HDR_LEN = 9,
  parameter int unsigned ID_W    = ROWS * COLS,
  parameter int unsigned LEN     = idfs_pkg::frame_len(ROWS, COLS, HDR_LEN)
) (
  input  logic [ID_W-1:0] id_i,
  output logic [LEN-1:0]  frame_o
);
  localparam int unsigned ROW_W   = COLS + 1;
  localparam int unsigned COL_POS = HDR_LEN + ROWS * ROW_W;

  assign frame_o[HDR_LEN-1:0] = '1;
  assign frame_o[LEN-1]       = 1'b0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int unsigned BASE = HDR_LEN + r * ROW_W;
    logic [COLS-1:0] row_bits;
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      assign row_bits[c]       = id_i[ID_W-1-r*COLS-c];
      assign frame_o[BASE + c] = row_bits[c];
    end
    assign frame_o[BASE + COLS] = ^row_bits;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_cell
      assign col_bits[r] = id_i[ID_W-1-r*COLS-c];
    end
    assign frame_o[COL_POS + c] = ^col_bits;
  end
endmodule

// File: rtl/id_frame_serializer.sv
module id_frame_serializer #(
  parameter int unsigned ROWS    = idfs_pkg::DEF_ROWS,
  parameter int unsigned COLS    = idfs_pkg::DEF_COLS,
  parameter int unsigned HDR_LEN = idfs_pkg::DEF_HDR,
  parameter int unsigned ID_W    = ROWS * COLS,
  parameter int unsigned LEN     = idfs_pkg::frame_len(ROWS, COLS, HDR_LEN),
  parameter int unsigned IDX_W   = $clog2(LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  id_i,
  input  logic             bit_adv_i,
  output logic             bit_o,
  output logic             frame_start_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  id_snap;
  logic [LEN-1:0]   frame;

  idfs_bit_counter #(.LEN(LEN), .IDX_W(IDX_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (bit_adv_i),
    .idx_o (idx)
  );

  idfs_id_capture #(.ID_W(ID_W), .HDR_LEN(HDR_LEN), .IDX_W(IDX_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (idx),
    .id_i  (id_i),
    .id_o  (id_snap)
  );

  idfs_frame_builder #(
    .ROWS(ROWS), .COLS(COLS), .HDR_LEN(HDR_LEN), .ID_W(ID_W), .LEN(LEN)
  ) u_bld (
    .id_i   (id_snap),
    .frame_o(frame)
  );

  assign bit_o         = frame[idx];
  assign frame_start_o = (idx == '0);
  assign bit_idx_o     = idx;

  assert_header_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_idx_o < IDX_W'(HDR_LEN)) |-> bit_o);
  assert_stop_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_idx_o == IDX_W'(LEN - 1)) |-> !bit_o);
  assert_start_after_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_adv_i && bit_idx_o == IDX_W'(LEN - 1)) |=> frame_start_o);
endmodule

// File: tb/id_frame_serializer_test.sv
module id_frame_serializer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] id_i = '0;
  logic        bit_adv_i = 1'b0;
  logic        bit_o;
  logic        frame_start_o;
  logic [5:0]  bit_idx_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam int NVEC = 6;
  localparam logic [39:0] ID_TAB [NVEC] = '{
    40'h00_0000_0000,
    40'hFF_FFFF_FFFF,
    40'hA5_5AA5_5A3C,
    40'h80_0000_0001,
    40'h12_3456_789A,
    40'hC3_0F1E_2D4B
  };

  always #10 clk_i = ~clk_i;

  id_frame_serializer uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .id_i         (id_i),
    .bit_adv_i    (bit_adv_i),
    .bit_o        (bit_o),
    .frame_start_o(frame_start_o),
    .bit_idx_o    (bit_idx_o)
  );

  function automatic logic exp_bit(logic [39:0] id, int idx);
    logic acc;
    int p;
    if (idx < 9) return 1'b1;
    if (idx == 63) return 1'b0;
    if (idx >= 59) begin
      acc = 1'b0;
      for (int r = 0; r < 10; r++) acc ^= id[39 - 4*r - (idx - 59)];
      return acc;
    end
    p = idx - 9;
    if (p % 5 < 4) return id[39 - 4*(p/5) - (p%5)];
    acc = 1'b0;
    for (int c = 0; c < 4; c++) acc ^= id[39 - 4*(p/5) - c];
    return acc;
  endfunction

  function automatic string tag_of(int idx);
    if (idx < 9) return "R4";
    if (idx == 63) return "R8";
    if (idx >= 59) return "R7";
    if ((idx - 9) % 5 == 4) return "R6";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; one rising edge with the strobe high
  task automatic adv_one();
    bit_adv_i = 1'b1;
    @(negedge clk_i);
    bit_adv_i = 1'b0;
  endtask

  // check indices from..to against id exp_id, advancing after each
  task automatic walk(logic [39:0] exp_id, int from, int to);
    for (int k = from; k <= to; k++) begin
      chk("R2", 64'(bit_idx_o), 64'(k));
      chk("R9", 64'(frame_start_o), 64'(k == 0));
      chk(tag_of(k), 64'(bit_o), 64'(exp_bit(exp_id, k)));
      adv_one();
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    id_i = ID_TAB[2];
    repeat (3) @(negedge clk_i);
    chk("R1", 64'(bit_idx_o), 64'd0);
    chk("R1", 64'(frame_start_o), 64'd1);
    chk("R1", 64'(bit_o), 64'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", 64'(bit_idx_o), 64'd0);
    chk("R1", 64'(frame_start_o), 64'd1);

    // no strobe: index holds
    repeat (4) @(negedge clk_i);
    chk("R2", 64'(bit_idx_o), 64'd0);

    // vector table: one whole frame per identifier, wrap checked at next start
    for (int i = 0; i < NVEC; i++) begin
      id_i = ID_TAB[i];
      walk(ID_TAB[i], 0, 63);
      chk("R3", 64'(bit_idx_o), 64'd0);
    end

    // R10: change during data part stays out of this frame
    id_i = ID_TAB[2];
    walk(ID_TAB[2], 0, 20);
    id_i = ID_TAB[5];
    walk(ID_TAB[2], 21, 63);
    walk(ID_TAB[5], 0, 63);

    // R10: change inside header is used by the same frame
    id_i = ID_TAB[3];
    walk(ID_TAB[5], 0, 4);
    id_i = ID_TAB[4];
    walk(ID_TAB[4], 5, 30);

    // R2: idle cycles between strobes keep index and bit
    repeat (3) @(negedge clk_i);
    chk("R2", 64'(bit_idx_o), 64'd31);
    chk("R5", 64'(bit_o), 64'(exp_bit(ID_TAB[4], 31)));
    walk(ID_TAB[4], 31, 63);
    chk("R3", 64'(bit_idx_o), 64'd0);
    chk("R9", 64'(frame_start_o), 64'd1);

    // reset mid-frame returns to header bit 0
    walk(ID_TAB[4], 0, 10);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", 64'(bit_idx_o), 64'd0);
    chk("R1", 64'(bit_o), 64'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    walk(ID_TAB[4], 0, 63);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule